// File: doc/BRIEF.md
# Asynchronous Static RAM Controller

This block sits between an on-chip requester and an external asynchronous static RAM of 131,072 bytes. The requester presents an address, a read/write flag and write data. The controller then generates the memory's strobes as a sequence of clocked phases: a low-active select, a high-active select, a low-active output enable and a low-active write enable. It also drives the 17-bit address bus. The shared byte bus is split into a data-out vector, a data-in vector and an output-enable. When the access finishes, the controller raises a one-cycle done pulse. After a read, it also presents the captured byte.

Every phase length is a whole number of clock cycles. Each is computed at elaboration time from nanosecond limits and the clock period, with rounding up and a floor of one cycle. A read holds the chip selected with output enable low until the slowest access path has elapsed. A write has three phases. It first waits with output enable high and the data bus released, long enough for the memory's outputs to float. It then opens the write window (both selects active and write enable low) with the controller driving the data. It ends with one hold cycle in which write enable is high again and address and data are unchanged. Between accesses the memory is deselected.

The state machine has five states. IDLE goes to RD_ACCESS on a read request and to WR_GAP on a write request. RD_ACCESS returns to IDLE when its timer expires. WR_GAP goes to WR_PULSE when its timer expires. WR_PULSE goes to WR_HOLD when its timer expires. WR_HOLD always returns to IDLE after one cycle. Reset forces IDLE from any state.

Top module: `sram_ctl`

## Requirements
- R1: Out of reset, and in every idle cycle, the strobes are: low-active select high, high-active select low, output enable high, write enable high, data bus released. `req_ready` is 1 and `rsp_done` is 0.
- R2: A read keeps both selects active, output enable low and write enable high for exactly ACC cycles. ACC is the largest of the address access, select access, output-enable access and read cycle limits, divided by the clock period, rounded up and at least 1. The byte on `mem_dq_in` at the end of the last of these cycles is the one returned.
- R3: `rsp_done` is high for exactly one cycle, the cycle after the last active phase of an access. On a read, `rsp_rdata` carries the byte in that same cycle and keeps it until the next read completes.
- R4: A write starts with GAP cycles in which both selects are active, output enable and write enable are high, and the data bus is released. GAP is the largest of the three output float limits in cycles, rounded up and at least 1.
- R5: The write window follows. Write enable is low and the bus carries the write data for PW cycles. PW is the largest of: the write-pulse, address-setup and data-setup limits in cycles, and the write cycle limit in cycles less GAP and 1. Write enable is never low unless both selects are active and the data bus is driven.
- R6: After the window, one cycle keeps both selects active, write enable high and the same address and data driven. The data bus is released only after that cycle.
- R7: The controller never drives the data bus while output enable is low, and never drives it while the chip is deselected.
- R8: A request is taken only while `req_ready` is high (idle). A request presented during an access is ignored: it causes no memory cycle and no done pulse, and it does not change the active access.
- R9: `mem_addr` stays constant from the first to the last active cycle of an access.
- R10: A synchronous active-high reset in any state returns the controller to idle on the next clock edge, with the R1 strobe levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High while idle; a request is taken when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last byte read |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_sel_n | output | 1 | Low-active chip select |
| mem_sel | output | 1 | High-active chip select |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | DATA_W | Byte driven onto the shared bus |
| mem_dq_in | input | DATA_W | Byte sampled from the shared bus |
| mem_dq_oe | output | 1 | Controller drives the shared bus when high |

## Verification
Every strobe is a direct decode of the state register, so a wrong state appears on the strobe pins in the same cycle. A timer that loads the wrong count shows up as a phase that is one or more cycles too short or too long. It is caught in the first access of that kind by per-cycle comparison of strobes, address and data. The memory model returns a poison byte until a read has lasted its full access time, so a read that captures too early returns the wrong data. A request that leaks through while busy shows up as an extra done pulse or as a changed byte when the untouched location is read back.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_RD_ACCESS = 3'd1,
        S_WR_GAP   = 3'd2,
        S_WR_PULSE = 3'd3,
        S_WR_HOLD  = 3'd4
    } ctl_state_e;

    // ceiling of ns / clk_ns, never below one cycle
    function automatic int ns_to_cycles(int ns, int clk_ns);
        int c;
        c = (ns + clk_ns - 1) / clk_ns;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_strobe_dec.sv
module sram_strobe_dec
    import sram_ctl_pkg::*;
(
    input  ctl_state_e state,
    output logic       sel_n,
    output logic       sel,
    output logic       oe_n,
    output logic       we_n,
    output logic       dq_oe
);

    always_comb begin
        sel_n = 1'b1;
        sel   = 1'b0;
        oe_n  = 1'b1;
        we_n  = 1'b1;
        dq_oe = 1'b0;
        unique case (state)
            S_IDLE: begin
            end
            S_RD_ACCESS: begin
                sel_n = 1'b0;
                sel   = 1'b1;
                oe_n  = 1'b0;
            end
            S_WR_GAP: begin
                sel_n = 1'b0;
                sel   = 1'b1;
            end
            S_WR_PULSE: begin
                sel_n = 1'b0;
                sel   = 1'b1;
                we_n  = 1'b0;
                dq_oe = 1'b1;
            end
            S_WR_HOLD: begin
                sel_n = 1'b0;
                sel   = 1'b1;
                dq_oe = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int ADDR_W        = 17,
    parameter int DATA_W        = 8,
    parameter int CLK_NS        = 10,
    parameter int ADDR_ACC_NS   = 15,
    parameter int SEL_ACC_NS    = 15,
    parameter int OE_ACC_NS     = 7,
    parameter int RD_CYC_NS     = 15,
    parameter int WR_CYC_NS     = 15,
    parameter int WE_MIN_NS     = 12,
    parameter int ADDR_SETUP_NS = 12,
    parameter int DATA_SETUP_NS = 10,
    parameter int OE_FLOAT_NS   = 6,
    parameter int SEL_FLOAT_NS  = 8,
    parameter int WE_FLOAT_NS   = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sel_n,
    output logic              mem_sel,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);

    // phase lengths in cycles
    localparam int ACC_CYC = max2(max2(ns_to_cycles(ADDR_ACC_NS, CLK_NS),
                                       ns_to_cycles(SEL_ACC_NS, CLK_NS)),
                                  max2(ns_to_cycles(OE_ACC_NS, CLK_NS),
                                       ns_to_cycles(RD_CYC_NS, CLK_NS)));
    localparam int GAP_CYC = max2(ns_to_cycles(OE_FLOAT_NS, CLK_NS),
                                  max2(ns_to_cycles(SEL_FLOAT_NS, CLK_NS),
                                       ns_to_cycles(WE_FLOAT_NS, CLK_NS)));
    localparam int PW_BASE = max2(ns_to_cycles(WE_MIN_NS, CLK_NS),
                                  max2(ns_to_cycles(ADDR_SETUP_NS, CLK_NS),
                                       ns_to_cycles(DATA_SETUP_NS, CLK_NS)));
    localparam int PW_CYC  = max2(PW_BASE, ns_to_cycles(WR_CYC_NS, CLK_NS) - GAP_CYC - 1);
    localparam int MAX_CYC = max2(ACC_CYC, max2(GAP_CYC, PW_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    ctl_state_e        state_q, state_nxt;
    logic              tmr_load, tmr_expired;
    logic [CNT_W-1:0]  tmr_val;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic              done_q;
    logic              accept;

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready;

    // next-state selection
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            S_IDLE:      if (req_valid) state_nxt = req_write ? S_WR_GAP : S_RD_ACCESS;
            S_RD_ACCESS: if (tmr_expired) state_nxt = S_IDLE;
            S_WR_GAP:    if (tmr_expired) state_nxt = S_WR_PULSE;
            S_WR_PULSE:  if (tmr_expired) state_nxt = S_WR_HOLD;
            S_WR_HOLD:   state_nxt = S_IDLE;
            default:     state_nxt = S_IDLE;
        endcase
    end

    // phase length loaded on every state change
    always_comb begin
        tmr_load = (state_nxt != state_q);
        unique case (state_nxt)
            S_RD_ACCESS: tmr_val = CNT_W'(ACC_CYC - 1);
            S_WR_GAP:    tmr_val = CNT_W'(GAP_CYC - 1);
            S_WR_PULSE:  tmr_val = CNT_W'(PW_CYC - 1);
            default:     tmr_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_nxt;
    end

    // request latch, capture and completion
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state_q == S_RD_ACCESS && tmr_expired) begin
                rdata_q <= mem_dq_in;
                done_q  <= 1'b1;
            end
            if (state_q == S_WR_HOLD) begin
                done_q <= 1'b1;
            end
        end
    end

    sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sram_strobe_dec strobe_i (
        .state (state_q),
        .sel_n (mem_sel_n),
        .sel   (mem_sel),
        .oe_n  (mem_oe_n),
        .we_n  (mem_we_n),
        .dq_oe (mem_dq_oe)
    );

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;
    assign rsp_done   = done_q;
    assign rsp_rdata  = rdata_q;

    // R7: never drive the bus while the memory may be driving it
    a_r7_no_contention: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n && !mem_sel_n && mem_sel));

    // R5: write enable low only inside a selected, driven window
    a_r5_we_window: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_sel_n && mem_sel && mem_dq_oe));

    // R6: data still driven in the cycle write enable returns high
    a_r6_hold_after_we: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_we_n) && !mem_sel_n) |-> mem_dq_oe);

    // R3: completion is a single-cycle pulse
    a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R9: address frozen across the active phases
    a_r9_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (state_q != S_IDLE && state_nxt != S_IDLE) |=> $stable(mem_addr));

    // R10: reset leaves the memory deselected and the bus released
    a_r10_reset_idle: assert property (@(posedge clk)
        rst |=> (mem_sel_n && !mem_sel && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_done));

endmodule

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;

    localparam int AW = 17;
    localparam int DW = 8;
    // bench timing: 20 ns clock, a slower memory grade
    localparam int CLK = 20;
    localparam int E_ACC = 3;  // ceil(50/20)
    localparam int E_GAP = 2;  // ceil(25/20)
    localparam int E_PW  = 3;  // max(ceil(30/20)=2, ceil(120/20)-2-1=3)

    localparam logic [4:0] ST_IDLE  = 5'b10110;
    localparam logic [4:0] ST_READ  = 5'b01010;
    localparam logic [4:0] ST_GAP   = 5'b01110;
    localparam logic [4:0] ST_PULSE = 5'b01101;
    localparam logic [4:0] ST_HOLD  = 5'b01111;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic rsp_done;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [DW-1:0] mem_dq_out;
    logic [DW-1:0] mem_dq_in = 8'hEE;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #(CLK/2) clk = ~clk;

    sram_ctl #(
        .CLK_NS(CLK), .ADDR_ACC_NS(50), .SEL_ACC_NS(15), .OE_ACC_NS(7),
        .RD_CYC_NS(15), .WR_CYC_NS(120), .WE_MIN_NS(30), .ADDR_SETUP_NS(12),
        .DATA_SETUP_NS(10), .OE_FLOAT_NS(6), .SEL_FLOAT_NS(25), .WE_FLOAT_NS(7)
    ) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
        .mem_sel_n(mem_sel_n), .mem_sel(mem_sel), .mem_oe_n(mem_oe_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
        .mem_dq_oe(mem_dq_oe)
    );

    // memory model: data valid only after the full access time
    logic [7:0] model [int];
    int rd_run = 0;
    wire chip_on = !mem_sel_n && mem_sel;

    always @(posedge clk) begin
        if (chip_on && !mem_we_n && mem_dq_oe) model[int'(mem_addr)] = mem_dq_out;
        if (chip_on && !mem_oe_n && mem_we_n) rd_run <= rd_run + 1;
        else rd_run <= 0;
    end

    always @(negedge clk) begin
        if (chip_on && !mem_oe_n && mem_we_n && rd_run >= E_ACC - 1)
            mem_dq_in <= model.exists(int'(mem_addr)) ? model[int'(mem_addr)] : 8'h00;
        else
            mem_dq_in <= 8'hEE;
    end

    function automatic logic [4:0] strobes();
        return {mem_sel_n, mem_sel, mem_oe_n, mem_we_n, mem_dq_oe};
    endfunction

    function automatic logic [31:0] bus_snap();
        return {2'b0, strobes(), mem_addr, (mem_dq_oe ? mem_dq_out : 8'h00)};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    // R1: idle levels after reset
    task automatic t_reset_state();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 idle strobes", {27'b0, strobes()}, {27'b0, ST_IDLE});
        chk("R1 ready/done", {30'b0, req_ready, rsp_done}, 32'b10);
    endtask

    // R4 R5 R6 R9 R3: full write, cycle by cycle
    task automatic t_write(logic [AW-1:0] a, logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < E_GAP; i++) begin
            if (i > 0) @(negedge clk);
            chk("R4 gap phase", bus_snap(), {2'b0, ST_GAP, a, 8'h00});
        end
        for (int i = 0; i < E_PW; i++) begin
            @(negedge clk);
            chk("R5 write window", bus_snap(), {2'b0, ST_PULSE, a, d});
        end
        @(negedge clk);
        chk("R6 hold cycle", bus_snap(), {2'b0, ST_HOLD, a, d});
        @(negedge clk);
        chk("R3 write done", {26'b0, strobes(), rsp_done}, {26'b0, ST_IDLE, 1'b1});
        @(negedge clk);
        chk("R3 done one cycle", {31'b0, rsp_done}, 32'b0);
    endtask

    // R2 R3 R9: read with access timing
    task automatic t_read(logic [AW-1:0] a, logic [DW-1:0] e);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < E_ACC; i++) begin
            if (i > 0) @(negedge clk);
            chk("R2 read phase", bus_snap(), {2'b0, ST_READ, a, 8'h00});
        end
        @(negedge clk);
        chk("R3 read done", {26'b0, strobes(), rsp_done}, {26'b0, ST_IDLE, 1'b1});
        chk("R2 read data", {24'b0, rsp_rdata}, {24'b0, e});
        @(negedge clk);
        chk("R3 done one cycle", {31'b0, rsp_done}, 32'b0);
    endtask

    // R8: request during a write is dropped
    task automatic t_busy_ignore();
        int dones;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00100; req_wdata = 8'h5A;
        @(negedge clk);
        req_addr = 17'h00200; req_wdata = 8'hC3;
        chk("R8 not ready while busy", {31'b0, req_ready}, 32'b0);
        @(negedge clk);
        chk("R8 active write unchanged", bus_snap(), {2'b0, ST_GAP, 17'h00100, 8'h00});
        @(negedge clk);
        chk("R8 window keeps first data", bus_snap(), {2'b0, ST_PULSE, 17'h00100, 8'h5A});
        req_valid = 1'b0;
        dones = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (rsp_done) dones++;
        end
        chk("R8 single done", dones, 1);
        chk("R8 idle after", {27'b0, strobes()}, {27'b0, ST_IDLE});
        chk("R3 rdata kept over write", {24'b0, rsp_rdata}, {24'b0, 8'hA7});
        t_read(17'h00200, 8'h11);
        t_read(17'h00100, 8'h5A);
    endtask

    // R10: reset in the middle of a read
    task automatic t_reset_mid();
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h1FFFF;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 read started", {27'b0, strobes()}, {27'b0, ST_READ});
        rst = 1'b1;
        @(negedge clk);
        chk("R10 idle after reset", {26'b0, strobes(), rsp_done}, {26'b0, ST_IDLE, 1'b0});
        rst = 1'b0;
        t_read(17'h1FFFF, 8'h3C);
    endtask

    initial begin
        t_reset_state();
        t_write(17'h00000, 8'hA5);
        t_write(17'h1FFFF, 8'h3C);
        t_write(17'h00200, 8'h11);
        t_read(17'h00000, 8'hA5);
        t_read(17'h1FFFF, 8'h3C);
        t_write(17'h0ABCD, 8'hA7);
        t_read(17'h0ABCD, 8'hA7);
        t_busy_ignore();
        t_reset_mid();
        finished = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            report();
        end
    end

endmodule